// File: doc/BRIEF.md
# Latched Host Register Bus Interface

This block is the host-facing front end of a serial communications peripheral. It turns a parallel host bus into per-register access enables. The bus has a 3-bit register address, three chip selects of mixed polarity and an address strobe. It also has a pair of read strobes and a pair of write strobes, and the two strobes in each pair have opposite polarity. The block drives a one-hot read enable and a one-hot write enable toward the register file. It also drives an output enable for the 8-bit read data bus and a driver-disable signal for an external bus transceiver.

The address and the chip-select decode pass through a transparent hold stage. While the address strobe is low, the live inputs reach the decode. While the strobe is high, the decode uses the value that was present at the last clock edge with the strobe low, so the host may change or release the address lines. All host inputs are sampled in the block clock domain and every output is registered.

A read enable lasts as long as a qualified read is held. A write enable is a single-cycle pulse on the trailing edge of the write strobe. Read and write asserted together is refused and flagged.

Top module: `hbi_host_front`

## Requirements
- R1: In reset and on the first cycle after it, `reg_rd_en`, `reg_wr_en` and `acc_clash` are all zero, `host_dout_oe` is all zeros and `xcvr_drv_dis` is 1.
- R2: While `host_ads_n` is 0, the address and chip selects sampled at a clock edge are the ones that decide the access whose outputs appear after that edge.
- R3: While `host_ads_n` is 1, the decode uses the address and select state sampled at the last clock edge where `host_ads_n` was 0. Changes on `host_addr` and the chip selects have no effect during that time.
- R4: The block is selected only when `host_cs_a`=1, `host_cs_b`=1 and `host_cs_c_n`=0. Each of the other seven combinations gives no read enable, no write pulse, no output enable and no clash flag.
- R5: A read is active when `host_rd_n`=0 or `host_rd`=1. A selected read with no write active sets bit [address] of `reg_rd_en` and sets all bits of `host_dout_oe` in the cycle after it is sampled. These outputs hold while the read is held.
- R6: `xcvr_drv_dis` is 1 and `host_dout_oe` is zero in every cycle that does not follow a sampled selected read. `xcvr_drv_dis` is 0 in every cycle that does follow one.
- R7: A write is active when `host_wr_n`=0 or `host_wr`=1. A selected write gives no enable while the strobe is held. In the cycle after the strobe is first sampled inactive, it gives a one-cycle pulse on bit [address] of `reg_wr_en`, using the address sampled on the last strobe cycle.
- R8: A read and a write active together while selected raise `acc_clash` in the following cycle and produce no read enable. Any write in progress is discarded, with no pulse when the strobes are released.
- R9: A write whose select is lost before the strobe is released produces no write pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_cs_a | input | 1 | Chip select, active high |
| host_cs_b | input | 1 | Chip select, active high |
| host_cs_c_n | input | 1 | Chip select, active low |
| host_ads_n | input | 1 | Address strobe; low = transparent, high = hold |
| host_rd_n | input | 1 | Read strobe, active low |
| host_rd | input | 1 | Read strobe, active high |
| host_wr_n | input | 1 | Write strobe, active low |
| host_wr | input | 1 | Write strobe, active high |
| reg_rd_en | output | 8 | One-hot register read enable |
| reg_wr_en | output | 8 | One-hot register write pulse |
| host_dout_oe | output | 8 | Per-bit output enable for the read data bus |
| xcvr_drv_dis | output | 1 | Transceiver driver disable, high unless reading |
| acc_clash | output | 1 | Read and write asserted together |

## Verification
The bench reads every address under all eight chip-select combinations with each read polarity. A wrong select decode shows up as enables for a deselected device, or as missing enables for the selected one. It writes every address with both write polarities and reads the data back through a stand-in register array. A write that fires on the leading edge, fires more than once or uses the wrong index would corrupt that data. Further cases check that the address is held while the strobe is high, and that a clash or a lost select in mid-write leaves no write pulse. A design that refreshes the hold stage while the strobe is high, or that keeps a write pending after a clash or a lost select, fails these cases.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_CLASH = 2'd3
  } acc_e;
endpackage

// File: rtl/hbi_addr_hold.sv
module hbi_addr_hold #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_c_n,
  output logic [ADDR_W-1:0] addr_eff,
  output logic              sel_eff
);
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_sel;
  logic              live_sel;

  assign live_sel = cs_a & cs_b & ~cs_c_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr <= '0;
      hold_sel  <= 1'b0;
    end else if (!strobe_n) begin
      hold_addr <= addr_in;
      hold_sel  <= live_sel;
    end
  end

  assign addr_eff = strobe_n ? hold_addr : addr_in;
  assign sel_eff  = strobe_n ? hold_sel  : live_sel;

  // R3: a high strobe freezes the captured state
  a_r3_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    strobe_n |=> ($stable(hold_addr) && $stable(hold_sel)));
endmodule

// File: rtl/hbi_strobe_qual.sv
module hbi_strobe_qual
  import hbi_pkg::*;
(
  input  logic rd_n,
  input  logic rd,
  input  logic wr_n,
  input  logic wr,
  input  logic sel,
  output acc_e kind,
  output logic wr_raw
);
  logic rd_act;
  logic wr_act;

  assign rd_act = ~rd_n | rd;
  assign wr_act = ~wr_n | wr;
  assign wr_raw = wr_act;

  always_comb begin
    kind = ACC_IDLE;
    if (sel) begin
      if (rd_act && wr_act) kind = ACC_CLASH;
      else if (rd_act)      kind = ACC_READ;
      else if (wr_act)      kind = ACC_WRITE;
    end
  end
endmodule

// File: rtl/hbi_access_gen.sv
module hbi_access_gen
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_e              kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_raw,
  output logic [NREG-1:0]   rd_en,
  output logic [NREG-1:0]   wr_en,
  output logic [DATA_W-1:0] oe,
  output logic              drv_dis,
  output logic              clash
);
  logic [NREG-1:0]   rd_dec;
  logic [NREG-1:0]   wr_dec;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_pend;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign rd_dec[i] = (addr    == ADDR_W'(i));
    assign wr_dec[i] = (wr_addr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= '0;
      wr_en   <= '0;
      oe      <= '0;
      drv_dis <= 1'b1;
      clash   <= 1'b0;
      wr_pend <= 1'b0;
      wr_addr <= '0;
    end else begin
      rd_en   <= (kind == ACC_READ) ? rd_dec : '0;
      oe      <= {DATA_W{kind == ACC_READ}};
      drv_dis <= (kind != ACC_READ);
      clash   <= (kind == ACC_CLASH);
      wr_pend <= (kind == ACC_WRITE);
      if (kind == ACC_WRITE) wr_addr <= addr;
      wr_en   <= (wr_pend && !wr_raw) ? wr_dec : '0;
    end
  end

  a_r5_rd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en));
  a_r5_oe_has_target: assert property (@(posedge clk) disable iff (rst)
    oe[0] |-> (rd_en != '0));
  a_r7_wr_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  a_r7_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr_en != '0) |=> (wr_en == '0));
  a_r8_clash_quiet: assert property (@(posedge clk) disable iff (rst)
    clash |-> (rd_en == '0 && oe == '0 && drv_dis));
endmodule

// File: rtl/hbi_host_front.sv
module hbi_host_front
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_cs_a,
  input  logic              host_cs_b,
  input  logic              host_cs_c_n,
  input  logic              host_ads_n,
  input  logic              host_rd_n,
  input  logic              host_rd,
  input  logic              host_wr_n,
  input  logic              host_wr,
  output logic [NREG-1:0]   reg_rd_en,
  output logic [NREG-1:0]   reg_wr_en,
  output logic [DATA_W-1:0] host_dout_oe,
  output logic              xcvr_drv_dis,
  output logic              acc_clash
);
  logic [ADDR_W-1:0] addr_eff;
  logic              sel_eff;
  acc_e              kind;
  logic              wr_raw;

  hbi_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .strobe_n(host_ads_n), .addr_in(host_addr),
    .cs_a(host_cs_a), .cs_b(host_cs_b), .cs_c_n(host_cs_c_n),
    .addr_eff(addr_eff), .sel_eff(sel_eff)
  );

  hbi_strobe_qual u_qual (
    .rd_n(host_rd_n), .rd(host_rd), .wr_n(host_wr_n), .wr(host_wr),
    .sel(sel_eff), .kind(kind), .wr_raw(wr_raw)
  );

  hbi_access_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gen (
    .clk(clk), .rst(rst), .kind(kind), .addr(addr_eff), .wr_raw(wr_raw),
    .rd_en(reg_rd_en), .wr_en(reg_wr_en), .oe(host_dout_oe),
    .drv_dis(xcvr_drv_dis), .clash(acc_clash)
  );

  // R4: a deselected cycle yields no access of any kind
  a_r4_deselect_idle: assert property (@(posedge clk) disable iff (rst)
    !sel_eff |=> (reg_rd_en == '0 && !acc_clash && host_dout_oe == '0));
  // R6: driver disable is the complement of a read in progress
  a_r6_drv_vs_oe: assert property (@(posedge clk) disable iff (rst)
    xcvr_drv_dis |-> (reg_rd_en == '0));
endmodule

// File: tb/test_hbi_host_front.sv
module test_hbi_host_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1, ads_n = 1'b0;
  logic       rd_n = 1'b1, rd = 1'b0, wr_n = 1'b1, wr = 1'b0;
  logic [7:0] rd_en, wr_en, oe;
  logic       drv_dis, clash;
  logic [7:0] mem [8];
  logic [7:0] exp_mem [8];
  logic [7:0] wdata = '0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hbi_host_front i_hbi_host_front (
    .clk(clk), .rst(rst), .host_addr(addr), .host_cs_a(cs_a), .host_cs_b(cs_b),
    .host_cs_c_n(cs_c_n), .host_ads_n(ads_n), .host_rd_n(rd_n), .host_rd(rd),
    .host_wr_n(wr_n), .host_wr(wr), .reg_rd_en(rd_en), .reg_wr_en(wr_en),
    .host_dout_oe(oe), .xcvr_drv_dis(drv_dis), .acc_clash(clash)
  );

  // stand-in register array
  always_ff @(posedge clk)
    for (int i = 0; i < 8; i++) if (wr_en[i]) mem[i] <= wdata;

  function automatic logic [7:0] rd_mux();
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (rd_en[i]) r = r | mem[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    rd_n = 1'b1; rd = 1'b0; wr_n = 1'b1; wr = 1'b0;
  endtask

  task automatic set_sel(input bit good);
    cs_a = good; cs_b = good; cs_c_n = !good;
  endtask

  task automatic check_quiet(input string req);
    chk(rd_en == 0 && wr_en == 0 && oe == 0 && drv_dis && !clash, req,
        {rd_en, wr_en, oe, 7'd0, drv_dis}, 32'h0000_0001);
  endtask

  task automatic do_read(input logic [2:0] a, input bit pol, input logic [2:0] cs);
    bit sel;
    @(negedge clk);
    addr = a; cs_a = cs[2]; cs_b = cs[1]; cs_c_n = cs[0];
    if (pol) rd = 1'b1; else rd_n = 1'b0;
    sel = (cs == 3'b110);
    @(negedge clk);
    if (sel) begin
      chk(rd_en == 8'(1 << a), "R5 read enable", rd_en, 8'(1 << a));
      chk(oe == 8'hFF && !drv_dis, "R6 oe/drv during read", {oe, drv_dis}, 9'h1FE);
      chk(rd_mux() == exp_mem[a], "R7 readback data", rd_mux(), exp_mem[a]);
    end else begin
      check_quiet("R4 deselected read");
    end
    idle_strobes();
    @(negedge clk);
    check_quiet("R6 idle after read");
  endtask

  task automatic do_write(input logic [2:0] a, input bit pol, input logic [7:0] d);
    @(negedge clk);
    addr = a; set_sel(1'b1); wdata = d;
    if (pol) wr = 1'b1; else wr_n = 1'b0;
    @(negedge clk);
    chk(wr_en == 0, "R7 no pulse while held", wr_en, 0);
    idle_strobes();
    addr = ~a;
    @(negedge clk);
    chk(wr_en == 8'(1 << a), "R7 trailing edge pulse", wr_en, 8'(1 << a));
    exp_mem[a] = d;
    @(negedge clk);
    chk(wr_en == 0, "R7 single pulse", wr_en, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after reset");

    // R7: writes with both polarities on every address
    for (int a = 0; a < 8; a++) do_write(3'(a), a[0], 8'(a * 37 + 5));

    // R4/R5: reads over all select combinations and both read polarities
    for (int cs = 0; cs < 8; cs++)
      for (int a = 0; a < 8; a++)
        for (int p = 0; p < 2; p++) do_read(3'(a), p[0], 3'(cs));

    // R2: transparent path follows address while strobe low
    @(negedge clk);
    set_sel(1'b1); ads_n = 1'b0; addr = 3'd1; rd_n = 1'b0;
    for (int a = 1; a < 8; a += 2) begin
      addr = 3'(a);
      @(negedge clk);
      chk(rd_en == 8'(1 << a), "R2 transparent follow", rd_en, 8'(1 << a));
    end
    idle_strobes();

    // R3: hold while strobe high
    @(negedge clk);
    addr = 3'd2; set_sel(1'b1); ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1; addr = 3'd5; set_sel(1'b0); rd = 1'b1;
    @(negedge clk);
    chk(rd_en == 8'h04, "R3 held address", rd_en, 8'h04);
    addr = 3'd7;
    @(negedge clk);
    chk(rd_en == 8'h04, "R3 still held", rd_en, 8'h04);
    ads_n = 1'b0;
    @(negedge clk);
    chk(rd_en == 8'h00, "R2 live deselect after release", rd_en, 8'h00);
    set_sel(1'b1);
    @(negedge clk);
    chk(rd_en == 8'h80, "R2 live address after release", rd_en, 8'h80);
    idle_strobes();
    @(negedge clk);
    check_quiet("R6 idle");

    // R8: clash flagged, no read
    addr = 3'd3; rd_n = 1'b0; wr = 1'b1;
    @(negedge clk);
    chk(clash && rd_en == 0 && drv_dis && oe == 0, "R8 clash flag",
        {clash, rd_en, drv_dis}, {1'b1, 8'h00, 1'b1});
    idle_strobes();
    @(negedge clk);
    chk(!clash, "R8 clash clears", clash, 0);

    // R8: clash in mid-write discards the write
    wr_n = 1'b0; addr = 3'd6;
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    idle_strobes();
    @(negedge clk);
    chk(wr_en == 0, "R8 write discarded", wr_en, 0);
    @(negedge clk);
    chk(wr_en == 0, "R8 write discarded later", wr_en, 0);

    // R9: select lost before trailing edge
    wr = 1'b1; addr = 3'd4; set_sel(1'b1);
    @(negedge clk);
    set_sel(1'b0);
    @(negedge clk);
    idle_strobes();
    @(negedge clk);
    chk(wr_en == 0, "R9 deselected write dropped", wr_en, 0);
    @(negedge clk);
    chk(wr_en == 0, "R9 no late pulse", wr_en, 0);

    // data untouched by discarded writes
    do_read(3'd6, 1'b0, 3'b110);
    do_read(3'd4, 1'b1, 3'b110);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule